// File: doc/BRIEF.md
# Synchronizable Interpolation Clock Divider

This block runs on the fast converter sample clock. It produces a slower clock at the input data rate, which is the fast rate divided by the chosen interpolation factor. External logic uses that slower clock to launch samples into the datapath. Its phase is fixed relative to the internal count, so the data arrives with a known alignment. A one-cycle data-phase pulse marks the fast-clock cycle in which each new divided period begins.

A phase strobe from outside can re-align the divider, but only when the sync enable is set. The strobe is synchronized into the fast domain. Its rising edge forces the counter back to the start of a period, so several such dividers, or a divider and a far-end source, can be brought into a common phase.

A separate disable input holds the divided-clock output low without stopping the count. The ratio select may change at any time. The new ratio is adopted only when the current period ends, so no short or stretched period is produced.

Top module: `rate_clock_divider`

## Requirements
- R1: The ratio select encodes the division factor as 0 = 2, 1 = 4, 2 = 8 and 3 = 16. Consecutive data-phase pulses are exactly that many fast-clock cycles apart.
- R2: The divided clock is high for the first half of each period, which is counts 0 up to factor/2 - 1, and low for the second half.
- R3: The data-phase output is high for exactly one fast cycle per period, in the cycle where the count is zero.
- R4: With sync enable high, consider the fast-clock edge that first samples the phase strobe high. After the second fast-clock edge following it, the divider is at count zero: data-phase is high and the divided clock is high.
- R5: With sync enable low, a phase strobe edge has no effect on the period.
- R6: A phase strobe held high restarts the divider only once. The next period after the restart has the full length.
- R7: While the output disable is high, the divided clock is held low. The count and the data-phase pulses continue unchanged.
- R8: A change of the ratio select takes effect at the next wrap of the counter. The period in progress completes at its old length.
- R9: During synchronous reset the count is zero and the ratio select is captured. The data-phase output and the divided clock (unless disabled) are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Division factor select (0:2, 1:4, 2:8, 3:16) |
| sync_en | input | 1 | Allows the phase strobe to restart the divider |
| phase_strobe | input | 1 | Asynchronous restart strobe, rising edge acts |
| out_disable | input | 1 | High forces the divided clock low |
| div_clk | output | 1 | Divided data-rate clock |
| data_phase | output | 1 | One-cycle pulse at count zero |

## Verification
A synchronized strobe edge can reach the counter in the same fast cycle as the counter's own wrap. It can also arrive while a ratio change is waiting for that wrap. The strobe path must then win: the count goes to zero, and the pending ratio stays pending. The bench places strobes at fixed offsets within a factor-16 period and checks the exact cycle at which data-phase reappears. A cycle-by-cycle model of count and strobe pipeline scores every sample. Any collision of restart, wrap and ratio change is therefore judged against the expected waveform.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    localparam int SEL_W = 2;
    localparam int CNT_W = 1 << SEL_W;

    typedef logic [SEL_W-1:0] ratio_sel_t;
    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic div_raw;
        logic phase;
    } tap_t;

    function automatic count_t last_count(ratio_sel_t s);
        int r;
        r = 2 << s;
        return count_t'(r - 1);
    endfunction

    function automatic count_t half_count(ratio_sel_t s);
        int h;
        h = 1 << s;
        return count_t'(h);
    endfunction

endpackage

// File: rtl/rcd_strobe_sync.sv
module rcd_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= '0;
            last_q <= 1'b0;
        end else begin
            pipe   <= {pipe[STAGES-2:0], strobe_in};
            last_q <= pipe[STAGES-1];
        end
    end

    assign rise = pipe[STAGES-1] & ~last_q;

    // R6: an edge is reported for a single cycle only
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/rcd_phase_counter.sv
module rcd_phase_counter
    import rcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ratio_sel_t ratio_sel,
    input  logic       restart,
    output count_t     cnt,
    output ratio_sel_t cur_sel
);
    logic at_end;

    assign at_end = (cnt == last_count(cur_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cur_sel <= ratio_sel;
        end else if (restart) begin
            cnt     <= '0;
        end else if (at_end) begin
            cnt     <= '0;
            cur_sel <= ratio_sel;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    p_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_count(cur_sel));

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(cur_sel));

endmodule

// File: rtl/rate_clock_divider.sv
module rate_clock_divider
    import rcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    input  logic       sync_en,
    input  logic       phase_strobe,
    input  logic       out_disable,
    output logic       div_clk,
    output logic       data_phase
);
    logic       strobe_rise;
    logic       restart;
    count_t     cnt;
    ratio_sel_t cur_sel;
    tap_t       tap;

    rcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (phase_strobe),
        .rise      (strobe_rise)
    );

    assign restart = strobe_rise & sync_en;

    rcd_phase_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel_t'(ratio_sel)),
        .restart   (restart),
        .cnt       (cnt),
        .cur_sel   (cur_sel)
    );

    always_comb begin
        tap.div_raw = (cnt < half_count(cur_sel));
        tap.phase   = (cnt == '0);
    end

    assign div_clk    = tap.div_raw & ~out_disable;
    assign data_phase = tap.phase;

    // R2: the period starts in the high half
    p_phase_high_r2: assert property (@(posedge clk) disable iff (rst)
        (data_phase && !out_disable) |-> div_clk);

    // R3: one pulse per period unless a restart intervenes
    p_pulse_once_r3: assert property (@(posedge clk) disable iff (rst)
        (data_phase && !restart) |=> !data_phase);

endmodule

// File: tb/rate_clock_divider_test.sv
module rate_clock_divider_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ratio_sel;
    logic       sync_en;
    logic       phase_strobe;
    logic       out_disable;
    logic       div_clk;
    logic       data_phase;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rate_clock_divider uut (
        .clk          (clk),
        .rst          (rst),
        .ratio_sel    (ratio_sel),
        .sync_en      (sync_en),
        .phase_strobe (phase_strobe),
        .out_disable  (out_disable),
        .div_clk      (div_clk),
        .data_phase   (data_phase)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model from the requirements; pushes expected outputs
    logic [1:0] exp_q[$];
    int  m_cnt, m_sel;
    bit  m_s1, m_s2, m_s3, m_restart;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sel = int'(ratio_sel);
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            m_restart = m_s2 & ~m_s3 & sync_en;
            if (m_restart) m_cnt = 0;
            else if (m_cnt == (2 << m_sel) - 1) begin
                m_cnt = 0; m_sel = int'(ratio_sel);
            end else m_cnt++;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = phase_strobe;
        end
        exp_q.push_back({m_cnt < (1 << m_sel), m_cnt == 0});
    end

    // monitor: pops one expected item per cycle
    always @(posedge clk) begin
        logic [1:0] e;
        #2;
        if (!done && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(div_clk === (e[1] & ~out_disable), "R2 div_clk", int'(div_clk), int'(e[1] & ~out_disable));
            check(data_phase === e[0], "R3 data_phase", int'(data_phase), int'(e[0]));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic gap(output int g);
        int guard = 0;
        while (data_phase !== 1'b1 && guard < 100) begin step(); guard++; end
        g = 0;
        do begin step(); g++; end while (data_phase !== 1'b1 && g < 100);
    endtask

    initial begin
        int g, highs, pulses;
        rst = 1; ratio_sel = 2'd3; sync_en = 1; phase_strobe = 0; out_disable = 0;
        repeat (3) step();
        check(data_phase === 1'b1, "R9 reset phase", int'(data_phase), 1);
        check(div_clk === 1'b1, "R9 reset div", int'(div_clk), 1);
        rst = 0;

        gap(g); check(g == 16, "R1 ratio 16", g, 16);
        ratio_sel = 2'd1;
        gap(g); check(g == 16, "R8 old length kept", g, 16);
        gap(g); check(g == 4, "R1 ratio 4", g, 4);
        ratio_sel = 2'd0;
        gap(g); check(g == 4, "R8 old length kept", g, 4);
        gap(g); check(g == 2, "R1 ratio 2", g, 2);
        ratio_sel = 2'd2;
        gap(g); gap(g); check(g == 8, "R1 ratio 8", g, 8);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            if (div_clk === 1'b1) highs++;
            step();
        end
        check(highs == 4, "R2 high half", highs, 4);

        ratio_sel = 2'd3;
        gap(g); gap(g);
        repeat (5) step();
        phase_strobe = 1;
        step();
        step(); check(data_phase === 1'b0, "R4 not yet", int'(data_phase), 0);
        step(); check(data_phase === 1'b1, "R4 restart phase", int'(data_phase), 1);
        check(div_clk === 1'b1, "R4 restart div", int'(div_clk), 1);
        gap(g); check(g == 16, "R6 held strobe", g, 16);
        phase_strobe = 0;

        sync_en = 0;
        gap(g);
        repeat (5) step();
        phase_strobe = 1;
        repeat (3) step();
        check(data_phase === 1'b0, "R5 ignored", int'(data_phase), 0);
        g = 0;
        while (data_phase !== 1'b1 && g < 100) begin step(); g++; end
        check(g == 8, "R5 period intact", g, 8);
        phase_strobe = 0;

        out_disable = 1;
        highs = 0; pulses = 0;
        for (int i = 0; i < 32; i++) begin
            step();
            if (div_clk !== 1'b0) highs++;
            if (data_phase === 1'b1) pulses++;
        end
        check(highs == 0, "R7 div held low", highs, 0);
        check(pulses == 2, "R7 pulses continue", pulses, 2);
        out_disable = 0;
        repeat (4) step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule